// File: doc/BRIEF.md
# D-Channel Contention Priority Controller

This block sits on the terminal side of a shared multipoint bus. It decides when the terminal may start sending on the common signalling (D) channel. It counts consecutive ones seen on the echo bit stream that the network side reflects back. When the count reaches the terminal value set by the current priority, and a transmission is pending, the block grants access. The HDLC framer then starts at once with its opening flag.

The terminal value comes from two settings. The first is a priority class that the user selects, high or low. The second is an internal sub-level inside that class. After a packet goes out successfully, the sub-level drops to the lower priority, which needs one more echo one. It rises again only once the terminal has counted that larger value.

While the block transmits, it compares every echo bit with the D bit it last sent. On a mismatch it withdraws the transmitter at once, signals the framer to drop the rest of the packet, and raises a collision interrupt. It keeps the access flag until the next frame pulse, and meanwhile counts again from zero.

Top module: `dch_access_ctl`

## Requirements
- R1: On each echo strobe, an echo one increments the consecutive-ones count and an echo zero clears it to zero.
- R2: The terminal count is 8 for the high class (`class_low_i`=0) at the high sub-level and 9 at the low sub-level. For the low class (`class_low_i`=1) it is 10 and 11.
- R3: In idle with `tx_req_i` high, `grant_o` and `d_tx_en_o` rise on the clock edge that samples the echo strobe that brings the count to the terminal value. With no request there is no grant. A request that arrives while the count is already at or above the terminal value is granted on the next edge.
- R4: The count saturates at the terminal value. While transmitting, echo bits are not counted and echo strobes before the first sent D bit cause no collision. The count restarts from zero after the packet.
- R5: `pkt_done_i` during transmission drops `grant_o` and `d_tx_en_o` on the next edge and lowers the sub-level, so the next access needs one more echo one.
- R6: The sub-level returns to high once the count reaches the low sub-level terminal value, whether or not a request is pending.
- R7: During transmission, an echo bit that differs from the last D bit sent drops `d_tx_en_o` on the next edge. On that same edge it pulses `tx_abort_o` for one cycle and raises `coll_irq_o`.
- R8: After a collision, `grant_o` stays high and `coll_irq_o` stays high until the edge that samples `frame_pulse_i`. The count restarts from zero right after the collision, and the collision leaves the sub-level unchanged.
- R9: After reset, all outputs are low, the sub-level is high and the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| e_stb_i | input | 1 | Echo bit valid strobe |
| e_bit_i | input | 1 | Echo bit value |
| d_stb_i | input | 1 | Strobe for a D bit placed on the line by this terminal |
| d_bit_i | input | 1 | D bit value placed on the line |
| frame_pulse_i | input | 1 | Frame boundary pulse |
| class_low_i | input | 1 | Priority class: 0 high, 1 low |
| tx_req_i | input | 1 | A packet is waiting to be sent |
| pkt_done_i | input | 1 | Packet completed successfully |
| grant_o | output | 1 | Access acknowledge flag |
| d_tx_en_o | output | 1 | Transmitter allowed to drive the D channel |
| tx_abort_o | output | 1 | One-cycle pulse: discard the rest of the packet |
| coll_irq_o | output | 1 | Collision interrupt, held until the next frame pulse |

## Verification
The bench checks the count boundary in every class and sub-level combination by stopping one echo one short of the terminal value. A design with an off-by-one or a swapped sub-level would grant early or late. It interrupts runs of ones with a zero; a design that only held the count would then grant too soon. It also checks that the sub-level comes back without a request, since a design that restored it only on a grant would stay at the larger count. After a collision, the bench confirms that the flag holds until the frame pulse and that a fresh run of eight ones is granted right after it. A design that kept the old count, or lowered the sub-level on the collision, would grant at the wrong time.

// File: rtl/dch_prio_pkg.sv
package dch_prio_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_BACK = 2'd2
  } acc_state_e;
endpackage

// File: rtl/dch_echo_counter.sv
module dch_echo_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_clr_i,
  input  logic             e_stb_i,
  input  logic             e_bit_i,
  input  logic [CNT_W-1:0] term_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             reach_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_clr_i)
      cnt_d = '0;
    else if (e_stb_i) begin
      if (!e_bit_i)
        cnt_d = '0;
      else if (cnt_q < term_i)
        cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // reach is evaluated on the next count so grant can follow the same edge
  assign reach_o = !hold_clr_i && (cnt_d >= term_i);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/dch_prio_level.sv
module dch_prio_level #(
  parameter int HI_CNT = 8,
  parameter int LO_CNT = 10,
  parameter int CNT_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             class_low_i,
  input  logic             lower_i,
  input  logic             reach_i,
  output logic [CNT_W-1:0] term_o,
  output logic             level_low_o
);
  localparam int NUM_TERMS = 4;
  logic [CNT_W-1:0] term_tab [NUM_TERMS];
  logic             level_q;

  for (genvar g = 0; g < NUM_TERMS; g++) begin : g_term
    localparam int BASE = (g / 2 == 0) ? HI_CNT : LO_CNT;
    assign term_tab[g] = CNT_W'(BASE + (g % 2));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  level_q <= 1'b0;
    else if (lower_i)             level_q <= 1'b1;
    else if (reach_i && level_q)  level_q <= 1'b0;
  end

  assign term_o      = term_tab[{class_low_i, level_q}];
  assign level_low_o = level_q;
endmodule

// File: rtl/dch_coll_det.sv
module dch_coll_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic d_stb_i,
  input  logic d_bit_i,
  input  logic e_stb_i,
  input  logic e_bit_i,
  output logic coll_o
);
  logic last_d_q, sent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_d_q <= 1'b0;
      sent_q   <= 1'b0;
    end else if (!active_i) begin
      sent_q   <= 1'b0;
    end else if (d_stb_i) begin
      last_d_q <= d_bit_i;
      sent_q   <= 1'b1;
    end
  end

  assign coll_o = active_i && sent_q && e_stb_i && (e_bit_i != last_d_q);
endmodule

// File: rtl/dch_access_ctl.sv
module dch_access_ctl
  import dch_prio_pkg::*;
#(
  parameter int HI_CNT = 8,
  parameter int LO_CNT = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic e_stb_i,
  input  logic e_bit_i,
  input  logic d_stb_i,
  input  logic d_bit_i,
  input  logic frame_pulse_i,
  input  logic class_low_i,
  input  logic tx_req_i,
  input  logic pkt_done_i,
  output logic grant_o,
  output logic d_tx_en_o,
  output logic tx_abort_o,
  output logic coll_irq_o
);
  localparam int CNT_W = $clog2(LO_CNT + 2);

  acc_state_e       state_q, state_d;
  logic [CNT_W-1:0] term_w, cnt_w;
  logic             reach_w, coll_w, level_low_w, abort_q;
  logic             sending, done_ok;

  assign sending = (state_q == ST_SEND);
  assign done_ok = sending && !coll_w && pkt_done_i;

  dch_echo_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_clr_i (sending),
    .e_stb_i    (e_stb_i),
    .e_bit_i    (e_bit_i),
    .term_i     (term_w),
    .cnt_o      (cnt_w),
    .reach_o    (reach_w)
  );

  dch_prio_level #(.HI_CNT(HI_CNT), .LO_CNT(LO_CNT), .CNT_W(CNT_W)) u_lvl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .class_low_i (class_low_i),
    .lower_i     (done_ok),
    .reach_i     (reach_w),
    .term_o      (term_w),
    .level_low_o (level_low_w)
  );

  dch_coll_det u_coll (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (sending),
    .d_stb_i  (d_stb_i),
    .d_bit_i  (d_bit_i),
    .e_stb_i  (e_stb_i),
    .e_bit_i  (e_bit_i),
    .coll_o   (coll_w)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (tx_req_i && reach_w) state_d = ST_SEND;
      ST_SEND: begin
        if (coll_w)          state_d = ST_BACK;
        else if (pkt_done_i) state_d = ST_IDLE;
      end
      ST_BACK: if (frame_pulse_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= coll_w;
    end
  end

  assign grant_o    = (state_q != ST_IDLE);
  assign d_tx_en_o  = sending;
  assign coll_irq_o = (state_q == ST_BACK);
  assign tx_abort_o = abort_q;
endmodule

// File: rtl/dch_access_chk.sv
module dch_access_chk #(
  parameter int LO_CNT = 10,
  parameter int CNT_W  = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             e_stb_i,
  input logic             e_bit_i,
  input logic             frame_pulse_i,
  input logic             tx_req_i,
  input logic             pkt_done_i,
  input logic             grant_o,
  input logic             d_tx_en_o,
  input logic             tx_abort_o,
  input logic             coll_irq_o,
  input logic [CNT_W-1:0] cnt_i
);
  a_r1_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    e_stb_i && !e_bit_i |=> cnt_i == '0);

  a_r2_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CNT_W'(LO_CNT + 1));

  a_r3_grant_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(d_tx_en_o) |-> $past(tx_req_i));

  a_r4_no_count_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_tx_en_o && $past(d_tx_en_o) |-> cnt_i == '0);

  a_r5_done_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    d_tx_en_o && pkt_done_i && !e_stb_i |=> !grant_o);

  a_r7_abort_stops_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> !d_tx_en_o && coll_irq_o);

  a_r8_ack_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_irq_o && !frame_pulse_i |=> grant_o);

  a_r8_ack_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_irq_o && frame_pulse_i |=> !grant_o && !coll_irq_o);
endmodule

bind dch_access_ctl dch_access_chk #(.LO_CNT(LO_CNT), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .e_stb_i       (e_stb_i),
  .e_bit_i       (e_bit_i),
  .frame_pulse_i (frame_pulse_i),
  .tx_req_i      (tx_req_i),
  .pkt_done_i    (pkt_done_i),
  .grant_o       (grant_o),
  .d_tx_en_o     (d_tx_en_o),
  .tx_abort_o    (tx_abort_o),
  .coll_irq_o    (coll_irq_o),
  .cnt_i         (cnt_w)
);

// File: tb/dch_access_ctl_test.sv
module dch_access_ctl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic e_stb = 0, e_bit = 0, d_stb = 0, d_bit = 0, fp = 0;
  logic cls_low = 0, req = 0, done = 0;
  logic grant, tx_en, abort, irq;
  int   n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  dch_access_ctl uut (
    .clk_i(clk), .rst_ni(rst_ni), .e_stb_i(e_stb), .e_bit_i(e_bit),
    .d_stb_i(d_stb), .d_bit_i(d_bit), .frame_pulse_i(fp),
    .class_low_i(cls_low), .tx_req_i(req), .pkt_done_i(done),
    .grant_o(grant), .d_tx_en_o(tx_en), .tx_abort_o(abort), .coll_irq_o(irq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic send_e(input logic b);
    e_stb = 1'b1; e_bit = b;
    @(negedge clk);
    e_stb = 1'b0;
  endtask

  task automatic ones(input int n);
    for (int i = 0; i < n; i++) send_e(1'b1);
  endtask

  task automatic send_d(input logic b);
    d_stb = 1'b1; d_bit = b;
    @(negedge clk);
    d_stb = 1'b0;
  endtask

  task automatic finish_pkt(input string tag);
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk({tag, " grant released"}, grant, 1'b0);
    chk({tag, " tx released"}, tx_en, 1'b0);
  endtask

  task automatic t_reset;
    chk("R9 grant", grant, 1'b0);
    chk("R9 tx_en", tx_en, 1'b0);
    chk("R9 abort", abort, 1'b0);
    chk("R9 irq", irq, 1'b0);
  endtask

  // high class, high level: zero in a run restarts count
  task automatic t_r1_zero_clears;
    req = 1'b1;
    ones(5); send_e(1'b0); ones(7);
    chk("R1 no grant after broken run", grant, 1'b0);
    send_e(1'b1);
    chk("R1 grant at 8th one", grant, 1'b1);
    chk("R3 tx_en with grant", tx_en, 1'b1);
    finish_pkt("R5");
  endtask

  // level lowered after success: high class needs 9
  task automatic t_r5_lowered;
    ones(8);
    chk("R5 no grant at 8 after success", grant, 1'b0);
    send_e(1'b1);
    chk("R5 grant at 9", grant, 1'b1);
    finish_pkt("R5");
  endtask

  // restore without request
  task automatic t_r6_restore;
    req = 1'b0;
    ones(9);
    chk("R3 no grant without request", grant, 1'b0);
    send_e(1'b0);
    req = 1'b1;
    ones(7);
    chk("R6 no grant at 7", grant, 1'b0);
    send_e(1'b1);
    chk("R6 grant at 8 after restore", grant, 1'b1);
    finish_pkt("R6");
  endtask

  task automatic t_r2_low_class;
    cls_low = 1'b1;
    ones(10);
    chk("R2 low class lowered no grant at 10", grant, 1'b0);
    send_e(1'b1);
    chk("R2 low class lowered grant at 11", grant, 1'b1);
    finish_pkt("R2");
    req = 1'b0;
    ones(11); send_e(1'b0);
    req = 1'b1;
    ones(9);
    chk("R2 low class high level no grant at 9", grant, 1'b0);
    send_e(1'b1);
    chk("R2 low class high level grant at 10", grant, 1'b1);
    finish_pkt("R2");
    cls_low = 1'b0;
  endtask

  task automatic t_r3_saturated;
    req = 1'b0;
    ones(12);
    chk("R4 saturated no request no grant", grant, 1'b0);
    req = 1'b1;
    @(negedge clk);
    chk("R3 late request granted", grant, 1'b1);
    ones(3); send_e(1'b0);
    chk("R4 echo before D bit no collision", tx_en, 1'b1);
    chk("R4 no abort", abort, 1'b0);
    finish_pkt("R4");
    send_e(1'b1);
    chk("R4 count restarted after packet", grant, 1'b0);
    send_e(1'b0);
  endtask

  task automatic t_r7_collision;
    ones(8);
    send_e(1'b1);
    chk("R7 granted before collision", grant, 1'b1);
    send_d(1'b0); send_e(1'b0);
    chk("R7 matching echo keeps tx", tx_en, 1'b1);
    send_d(1'b1); send_e(1'b0);
    chk("R7 tx dropped", tx_en, 1'b0);
    chk("R7 abort pulse", abort, 1'b1);
    chk("R7 irq raised", irq, 1'b1);
    chk("R8 grant held", grant, 1'b1);
    @(negedge clk);
    chk("R7 abort one cycle", abort, 1'b0);
    ones(8);
    chk("R8 grant held until frame", grant, 1'b1);
    chk("R8 irq held until frame", irq, 1'b1);
    fp = 1'b1;
    @(negedge clk);
    fp = 1'b0;
    chk("R8 grant cleared at frame", grant, 1'b0);
    chk("R8 irq cleared at frame", irq, 1'b0);
    @(negedge clk);
    chk("R8 recount kept high level", grant, 1'b1);
    finish_pkt("R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_r1_zero_clears();
    t_r5_lowered();
    t_r6_restore();
    t_r2_low_class();
    t_r3_saturated();
    t_r7_collision();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule